// File: doc/BRIEF.md
# Two-Stage Watchdog Timer With Lockable Control

This block is a watchdog timer on a simple register bus. A down-counter is loaded from a programmable load value and decrements once per clock while the watchdog is armed. When the count reaches zero, the block records a time-out, reloads the counter and keeps counting. The first time-out raises an interrupt, which software is expected to service and clear. If the interrupt is still uncleared when the next time-out arrives, the block issues a one-cycle reset request, provided the reset path has been enabled.

The control register arms the watchdog. Once its interrupt-enable bit is set, the control register locks: later bus writes to it have no effect, and only the synchronous hardware reset input unlocks it. The register bus has an address, a write strobe, write data and combinational read data. There are five registers: load value, current count, control, interrupt clear and raw status.

Top module: `dual_stage_wdog`

## Requirements
- R1: After reset the control register reads 0, the raw status reads 0, irq_o and rst_req_o are 0, and both the load value and the current count read LOAD_RST.
- R2: Control (offset 0x008) bit 0 is the interrupt enable and bit 1 is the reset enable. Bits 31:2 read as zero whatever was written.
- R3: Setting the interrupt enable loads the counter from the load value. While the enable is 1 the count decrements by one per clock. While the enable is 0 the count holds.
- R4: Once the interrupt enable is 1, every bus write to the control register is ignored, including writes that try to clear either bit. Only the reset input returns the register to 0.
- R5: A write to the load register (offset 0x000) updates the load value and reloads the counter on the same edge. This write takes precedence over a time-out. The current count (offset 0x004) is read-only, and writes to it are ignored.
- R6: An edge at which the armed counter is 0 is a time-out. The time-out sets the raw status and reloads the counter from the load value, so with load value L a time-out occurs every L+1 cycles.
- R7: The raw status reads at offset 0x010 bit 0. irq_o is high exactly while the raw status and the interrupt enable are both 1.
- R8: A write of any value to offset 0x00C clears the raw status without reloading the counter. If a time-out falls on the same edge, the status ends up set.
- R9: A time-out that finds the raw status already set, with the reset enable at 1, makes rst_req_o high for exactly the following cycle. rst_req_o is never high in two consecutive cycles, and a time-out after the status was cleared raises no reset request.
- R10: While the reset enable is 0, rst_req_o stays 0 whatever the time-out history.
- R11: Addresses outside the five registers read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt level |
| rst_req_o | output | 1 | One-cycle reset request pulse |

## Verification
The bench builds the block with CNT_W = 16 and ADDR_W = 8, which leaves LOAD_RST at 0xFFFF. Small load values written over the bus then bring several time-out periods into a few dozen cycles. That window covers the exact cycle of each time-out, a status clear that lands on a time-out edge, and a load of zero, where every cycle is a time-out and the reset pulses must alternate. Hardware reset is applied between scenarios, because nothing else can undo the lock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int BUS_W = 32;

    localparam logic [31:0] OFS_LOAD  = 32'h0000_0000;
    localparam logic [31:0] OFS_COUNT = 32'h0000_0004;
    localparam logic [31:0] OFS_CTRL  = 32'h0000_0008;
    localparam logic [31:0] OFS_ICLR  = 32'h0000_000C;
    localparam logic [31:0] OFS_STAT  = 32'h0000_0010;

    typedef struct packed {
        logic rst_en;
        logic irq_en;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LOAD,
        SEL_COUNT,
        SEL_CTRL,
        SEL_ICLR,
        SEL_STAT
    } sel_e;

    typedef struct packed {
        logic wr_load;
        logic arm;
        logic wr_iclr;
    } strobe_t;

    function automatic sel_e decode(input logic [31:0] a);
        sel_e s;
        case (a)
            OFS_LOAD:  s = SEL_LOAD;
            OFS_COUNT: s = SEL_COUNT;
            OFS_CTRL:  s = SEL_CTRL;
            OFS_ICLR:  s = SEL_ICLR;
            OFS_STAT:  s = SEL_STAT;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              status,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load,
    output strobe_t           stb,
    output logic [BUS_W-1:0]  rdata
);

    sel_e sel;
    logic ctrl_wr;

    always_comb begin
        sel         = decode(32'(addr));
        ctrl_wr     = we && (sel == SEL_CTRL) && !ctrl.irq_en;
        stb.wr_load = we && (sel == SEL_LOAD);
        stb.arm     = ctrl_wr && wdata[0];
        stb.wr_iclr = we && (sel == SEL_ICLR);
    end

    // Control: frozen once armed, only the reset input releases it.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.rst_en <= wdata[1];
            ctrl.irq_en <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load <= LOAD_RST;
        end else if (stb.wr_load) begin
            load <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_LOAD:  rdata = BUS_W'(load);
            SEL_COUNT: rdata = BUS_W'(count);
            SEL_CTRL:  rdata = BUS_W'({ctrl.rst_en, ctrl.irq_en});
            SEL_STAT:  rdata = BUS_W'(status);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W = 32,
    parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wr_load,
    input  logic [CNT_W-1:0] new_load,
    input  logic             arm,
    input  logic [CNT_W-1:0] load,
    output logic [CNT_W-1:0] count,
    output logic             tmo
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // A bus load write wins over a time-out on the same edge.
    assign tmo = run && (count == '0) && !wr_load && !arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= LOAD_RST;
        end else if (wr_load) begin
            count <= new_load;
        end else if (arm || tmo) begin
            count <= load;
        end else if (run) begin
            count <= count - ONE;
        end
    end

endmodule

// File: rtl/wdg_stage.sv
module wdg_stage (
    input  logic clk,
    input  logic rst,
    input  logic tmo,
    input  logic clr,
    input  logic irq_en,
    input  logic rst_en,
    output logic status,
    output logic irq,
    output logic rst_pulse
);

    logic second;

    assign second = tmo && status && rst_en;
    assign irq    = status && irq_en;

    // Set has priority over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (tmo) begin
            status <= 1'b1;
        end else if (clr) begin
            status <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= second && !rst_pulse;
        end
    end

endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);

    ctrl_t            ctrl_q;
    strobe_t          stb;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] count_q;
    logic             tmo;
    logic             status_q;

    wdg_regs #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .LOAD_RST(LOAD_RST)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .count (count_q),
        .status(status_q),
        .ctrl  (ctrl_q),
        .load  (load_q),
        .stb   (stb),
        .rdata (bus_rdata)
    );

    wdg_counter #(
        .CNT_W   (CNT_W),
        .LOAD_RST(LOAD_RST)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.irq_en),
        .wr_load (stb.wr_load),
        .new_load(bus_wdata[CNT_W-1:0]),
        .arm     (stb.arm),
        .load    (load_q),
        .count   (count_q),
        .tmo     (tmo)
    );

    wdg_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .tmo      (tmo),
        .clr      (stb.wr_iclr),
        .irq_en   (ctrl_q.irq_en),
        .rst_en   (ctrl_q.rst_en),
        .status   (status_q),
        .irq      (irq_o),
        .rst_pulse(rst_req_o)
    );

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_en,
    input logic             rst_en,
    input logic             arm,
    input logic             wr_load,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] load,
    input logic             tmo,
    input logic             status,
    input logic             irq_o,
    input logic             rst_req_o
);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!irq_en && !wr_load && !arm) |=> $stable(count));

    p_decrement_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_en && count != '0 && !wr_load) |=> count == $past(count) - CNT_W'(1));

    p_ctrl_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        irq_en |=> (irq_en && $stable(rst_en)));

    p_reload_r6: assert property (@(posedge clk) disable iff (rst)
        tmo |=> (count == $past(load) && status));

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(tmo));

    p_rst_single_r9: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> !rst_req_o);

    p_rst_second_r9: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> ($past(status) && $past(tmo)));

    p_rst_gated_r10: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> rst_en);

endmodule

bind dual_stage_wdog wdg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_en   (ctrl_q.irq_en),
    .rst_en   (ctrl_q.rst_en),
    .arm      (stb.arm),
    .wr_load  (stb.wr_load),
    .count    (count_q),
    .load     (load_q),
    .tmo      (tmo),
    .status   (status_q),
    .irq_o    (irq_o),
    .rst_req_o(rst_req_o)
);

// File: tb/dual_stage_wdog_test.sv
`timescale 1ns/1ps
module dual_stage_wdog_test;

    localparam int ADDR_W = 8;
    localparam int CNT_W  = 16;
    localparam logic [7:0] A_LOAD  = 8'h00;
    localparam logic [7:0] A_COUNT = 8'h04;
    localparam logic [7:0] A_CTRL  = 8'h08;
    localparam logic [7:0] A_ICLR  = 8'h0C;
    localparam logic [7:0] A_STAT  = 8'h10;
    localparam logic [7:0] A_HOLE  = 8'h14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_o;
    logic              rst_req_o;

    int errors = 0;
    int total  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    dual_stage_wdog #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o),
        .rst_req_o(rst_req_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors++;
            total++;
            $display("FAIL watchdog (all requirements): actual=%0d cycles expected<=20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_we = 1'b0;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic test_reset_state();
        logic [31:0] v;
        do_reset();
        rd(A_CTRL, v);  chk("R1 ctrl after reset", v, 0);
        rd(A_STAT, v);  chk("R1 status after reset", v, 0);
        rd(A_LOAD, v);  chk("R1 load after reset", v, 32'hFFFF);
        rd(A_COUNT, v); chk("R1 count after reset", v, 32'hFFFF);
        chk("R1 irq_o after reset", irq_o, 0);
        chk("R1 rst_req_o after reset", rst_req_o, 0);
        repeat (4) @(negedge clk);
        rd(A_COUNT, v); chk("R3 count holds while disarmed", v, 32'hFFFF);
    endtask

    task automatic test_ctrl_fields();
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd(A_CTRL, v); chk("R2 only bit1 kept, upper bits zero", v, 2);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); chk("R4 unarmed ctrl stays writable", v, 0);
    endtask

    task automatic test_load_and_map();
        logic [31:0] v;
        wr(A_LOAD, 32'd10);
        rd(A_LOAD, v);  chk("R5 load value written", v, 10);
        rd(A_COUNT, v); chk("R5 counter reloaded by load write", v, 10);
        wr(A_COUNT, 32'd3);
        rd(A_COUNT, v); chk("R5 count is read-only", v, 10);
        wr(A_HOLE, 32'hFFFF_FFFF);
        rd(A_HOLE, v);  chk("R11 unmapped reads zero", v, 0);
        rd(A_CTRL, v);  chk("R11 unmapped write leaves ctrl", v, 0);
        rd(A_LOAD, v);  chk("R11 unmapped write leaves load", v, 10);
    endtask

    task automatic test_two_stage();
        logic [31:0] v;
        logic [31:0] c0;
        bit seen;
        bit bad;
        do_reset();
        wr(A_LOAD, 32'd5);
        wr(A_CTRL, 32'd3);
        rd(A_COUNT, v); chk("R3 arming loads counter", v, 5);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            rd(A_COUNT, v); chk("R3 count decrements", v, 5 - k);
        end
        @(negedge clk);
        rd(A_COUNT, v); chk("R6 reload at time-out", v, 5);
        rd(A_STAT, v);  chk("R6 status set at time-out", v, 1);
        chk("R7 irq_o follows status", irq_o, 1);
        chk("R9 no reset on first time-out", rst_req_o, 0);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); chk("R4 write to armed ctrl ignored", v, 3);
        seen = 0;
        for (int k = 0; k < 7 && !seen; k++) begin
            @(negedge clk);
            if (rst_req_o) seen = 1;
        end
        chk("R9 reset on second time-out", seen, 1);
        @(negedge clk);
        chk("R9 reset pulse lasts one cycle", rst_req_o, 0);
        rd(A_STAT, v); chk("R6 status stays set", v, 1);
        rd(A_COUNT, c0);
        if (c0 == 0) begin
            @(negedge clk);
            rd(A_COUNT, c0);
        end
        wr(A_ICLR, 32'h1234_5678);
        rd(A_STAT, v);  chk("R8 clear drops status", v, 0);
        chk("R7 irq_o low after clear", irq_o, 0);
        rd(A_COUNT, v); chk("R8 clear does not reload", v, c0 - 1);
        seen = 0;
        bad = 0;
        for (int k = 0; k < 8 && !seen; k++) begin
            @(negedge clk);
            if (rst_req_o) bad = 1;
            rd(A_STAT, v);
            if (v == 1) seen = 1;
        end
        chk("R6 time-out after clear sets status", seen, 1);
        chk("R9 no reset after cleared status", bad, 0);
    endtask

    task automatic test_reset_disabled();
        logic [31:0] v;
        bit bad;
        do_reset();
        rd(A_CTRL, v); chk("R4 hardware reset unlocks ctrl", v, 0);
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, 32'd1);
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (rst_req_o) bad = 1;
        end
        chk("R10 no reset with reset enable 0", bad, 0);
        rd(A_STAT, v); chk("R10 time-outs still recorded", v, 1);
        chk("R7 irq_o high while armed and pending", irq_o, 1);
        wr(A_CTRL, 32'd3);
        rd(A_CTRL, v); chk("R4 reset enable cannot be added after lock", v, 1);
    endtask

    task automatic test_clear_race();
        logic [31:0] v;
        do_reset();
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, 32'd1);
        for (int k = 0; k < 10; k++) begin
            rd(A_COUNT, v);
            if (v == 0) break;
            @(negedge clk);
        end
        wr(A_ICLR, 32'd0);
        rd(A_STAT, v);  chk("R8 time-out wins over clear", v, 1);
        rd(A_COUNT, v); chk("R6 reload on time-out edge", v, 3);
        wr(A_LOAD, 32'd7);
        rd(A_COUNT, v); chk("R5 load write reloads running counter", v, 7);
        @(negedge clk);
        rd(A_COUNT, v); chk("R3 counting continues from new load", v, 6);
    endtask

    task automatic test_zero_load();
        int highs;
        int consec;
        bit prev;
        do_reset();
        wr(A_LOAD, 32'd0);
        wr(A_CTRL, 32'd3);
        highs = 0;
        consec = 0;
        prev = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (rst_req_o) begin
                highs++;
                if (prev) consec++;
            end
            prev = rst_req_o;
        end
        chk("R9 zero load never gives back-to-back pulses", consec, 0);
        chk("R9 zero load gives reset pulses", highs > 0, 1);
    endtask

    initial begin
        test_reset_state();
        test_ctrl_fields();
        test_load_and_map();
        test_two_stage();
        test_reset_disabled();
        test_clear_race();
        test_zero_load();
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

endmodule